// File: doc/BRIEF.md
# Double-Precision Multiply Special-Value Resolver

This combinational unit sits in front of a double-precision multiplier. It looks at the two IEEE-754 binary64 operands and decides whether the product is fixed by the special-value rules of the standard rather than by the arithmetic. When it is, the unit supplies the final 64-bit word on a bypass path. It also reports whether the invalid-operation flag must be raised or an invalid trap taken.

When no special case applies, the bypass flag stays low and the neighbouring datapath produces the product from the same operands. That datapath also handles normalisation of subnormal operands, mantissa multiplication, rounding, overflow and underflow.

NaN handling follows a fixed operand priority. A signalling NaN in operand A is chosen first. A signalling NaN in operand B is chosen next. Otherwise a NaN operand A is passed through as it is. An enabled invalid trap suppresses the bypass result entirely.

Top module: `fmul_special_resolve`

## Requirements
- R1: Every infinity or zero result carries a sign bit (bit 63) equal to the XOR of the two operand sign bits.
- R2: An infinity (exponent bits 62:52 all ones, mantissa bits 51:0 zero) multiplied by a zero (exponent and mantissa both zero), in either order, is invalid. With the trap disabled, the unit asserts the bypass and the invalid flag, and the result is 64'h7FF8_0000_0000_0000.
- R3: Whenever an invalid condition arises with the trap enable high, the trap request is high, and both the bypass flag and the invalid flag are low.
- R4: An infinity multiplied by a non-NaN, non-zero operand (normal, subnormal or infinity) gives a signed infinity with no flag and no trap.
- R5: When operand A is a NaN (exponent all ones, mantissa non-zero), three cases apply, in this order:
  - If A is signalling (mantissa bit 51 = 0), the result is A with bit 51 set, and invalid is raised.
  - Otherwise, if B is a signalling NaN, the result is B with bit 51 set, and invalid is raised.
  - Otherwise the result is A unchanged, with no exception.
- R6: When only operand B is a NaN, the result is B. If B is signalling, bit 51 is set and invalid is raised; if B is quiet, B is returned unchanged with no exception.
- R7: A zero multiplied by a finite operand (in either order) gives a signed zero with no exception.
- R8: When no special case applies (both operands finite and non-zero), the bypass flag, invalid flag and trap request are all low, and the result word is zero.
- R9: The invalid flag and the trap request are never high together. The trap request is only high when the trap enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | First binary64 operand |
| op_b | input | 64 | Second binary64 operand |
| inv_trap_en | input | 1 | Invalid-operation trap enable |
| byp_valid | output | 1 | Result is decided by the special-value rules |
| byp_result | output | 64 | Special-value result, zero when byp_valid is low |
| inv_flag_set | output | 1 | Request to set the invalid-operation flag |
| inv_trap_req | output | 1 | Request to take the invalid-operation trap |

## Verification
The immediate assertions inside the unit assume that the inputs are settled two-state values. They also assume that an operand's class is decided only by its exponent and mantissa fields, so any bit pattern is legal input.

The bench builds each operand from a chosen class: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. Each class has a random sign and random payload. A signalling NaN is always given a non-zero mantissa with bit 51 clear, so it can never collapse into an infinity. Directed vectors pin the NaN priority order and the trap-enable variants of each invalid case.

// File: rtl/fmul_special_resolve.sv
module fmul_special_resolve (
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  input  logic        inv_trap_en,
  output logic        byp_valid,
  output logic [63:0] byp_result,
  output logic        inv_flag_set,
  output logic        inv_trap_req
);

  localparam logic [10:0] EXP_ONES = 11'h7FF;
  localparam logic [63:0] QNAN_DFLT = 64'h7FF8_0000_0000_0000;

  logic [10:0] a_exp, b_exp;
  logic [51:0] a_man, b_man;
  logic        a_expmax, b_expmax, a_manz, b_manz;
  logic        a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, a_zero, b_zero;
  logic        res_sign;

  assign a_exp = op_a[62:52];
  assign b_exp = op_b[62:52];
  assign a_man = op_a[51:0];
  assign b_man = op_b[51:0];

  assign a_expmax = (a_exp == EXP_ONES);
  assign b_expmax = (b_exp == EXP_ONES);
  assign a_manz   = (a_man == '0);
  assign b_manz   = (b_man == '0);

  assign a_nan  = a_expmax & ~a_manz;
  assign b_nan  = b_expmax & ~b_manz;
  assign a_snan = a_nan & ~a_man[51];
  assign b_snan = b_nan & ~b_man[51];
  assign a_inf  = a_expmax & a_manz;
  assign b_inf  = b_expmax & b_manz;
  assign a_zero = (a_exp == '0) & a_manz;
  assign b_zero = (b_exp == '0) & b_manz;

  assign res_sign = op_a[63] ^ op_b[63];

  logic        hit;
  logic        invalid;
  logic [63:0] pick;

  always_comb begin
    hit     = 1'b1;
    invalid = 1'b0;
    pick    = '0;
    if (a_nan) begin
      if (a_snan) begin
        invalid = 1'b1;
        pick    = op_a | (64'd1 << 51);
      end else if (b_snan) begin
        invalid = 1'b1;
        pick    = op_b | (64'd1 << 51);
      end else begin
        pick = op_a;
      end
    end else if (a_inf && !b_nan) begin
      if (b_zero) begin
        invalid = 1'b1;
        pick    = QNAN_DFLT;
      end else begin
        pick = {res_sign, EXP_ONES, 52'd0};
      end
    end else if (b_nan) begin
      if (b_snan) begin
        invalid = 1'b1;
        pick    = op_b | (64'd1 << 51);
      end else begin
        pick = op_b;
      end
    end else if (b_inf) begin
      if (a_zero) begin
        invalid = 1'b1;
        pick    = QNAN_DFLT;
      end else begin
        pick = {res_sign, EXP_ONES, 52'd0};
      end
    end else if (a_zero || b_zero) begin
      pick = {res_sign, 63'd0};
    end else begin
      hit = 1'b0;
    end
  end

  assign inv_trap_req = invalid & inv_trap_en;
  assign inv_flag_set = invalid & ~inv_trap_en;
  assign byp_valid    = hit & ~inv_trap_req;
  assign byp_result   = byp_valid ? pick : 64'd0;

  always_comb begin
    // R9
    trap_flag_excl_chk: assert (!(inv_trap_req && inv_flag_set));
    // R9
    trap_needs_en_chk: assert (!inv_trap_req || inv_trap_en);
    // R3
    trap_kills_result_chk: assert (!inv_trap_req || !byp_valid);
    // R8
    idle_result_zero_chk: assert (byp_valid || byp_result == 64'd0);
    // R5
    flag_gives_qnan_chk: assert (!inv_flag_set ||
      (byp_valid && byp_result[62:52] == EXP_ONES && byp_result[51]));
    // R1
    inf_zero_sign_chk: assert (!(byp_valid && byp_result[51:0] == '0 &&
      (byp_result[62:52] == '0 || byp_result[62:52] == EXP_ONES)) ||
      byp_result[63] == res_sign);
  end

endmodule

// File: tb/fmul_special_resolve_tb.sv
module fmul_special_resolve_tb;

  logic        clk = 1'b0;
  logic [63:0] op_a, op_b;
  logic        inv_trap_en;
  logic        byp_valid, inv_flag_set, inv_trap_req;
  logic [63:0] byp_result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fmul_special_resolve u_dut (
    .op_a(op_a), .op_b(op_b), .inv_trap_en(inv_trap_en),
    .byp_valid(byp_valid), .byp_result(byp_result),
    .inv_flag_set(inv_flag_set), .inv_trap_req(inv_trap_req)
  );

  localparam logic [63:0] QN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] QB = 64'h0008_0000_0000_0000;

  function automatic bit is_nan(logic [63:0] x);
    return x[62:52] == 11'h7FF && x[51:0] != 0;
  endfunction
  function automatic bit is_inf(logic [63:0] x);
    return x[62:52] == 11'h7FF && x[51:0] == 0;
  endfunction
  function automatic bit is_zero(logic [63:0] x);
    return x[62:0] == 0;
  endfunction
  function automatic bit is_snan(logic [63:0] x);
    return is_nan(x) && !x[51];
  endfunction

  // returns {valid, flag, trap, result}
  function automatic logic [66:0] model(logic [63:0] a, logic [63:0] b, logic te);
    logic s = a[63] ^ b[63];
    logic inv = 1'b0;
    logic hit = 1'b1;
    logic [63:0] r = 0;
    if (is_nan(a)) begin
      if (is_snan(a)) begin inv = 1; r = a | QB; end
      else if (is_snan(b)) begin inv = 1; r = b | QB; end
      else r = a;
    end else if (is_nan(b)) begin
      inv = is_snan(b); r = b | (is_snan(b) ? QB : 64'd0);
    end else if (is_inf(a) || is_inf(b)) begin
      if (is_zero(a) || is_zero(b)) begin inv = 1; r = QN; end
      else r = {s, 11'h7FF, 52'd0};
    end else if (is_zero(a) || is_zero(b)) r = {s, 63'd0};
    else hit = 0;
    if (inv && te) return {1'b0, 1'b0, 1'b1, 64'd0};
    if (!hit) return {3'b000, 64'd0};
    return {1'b1, inv, 1'b0, r};
  endfunction

  function automatic string tag_of(logic [63:0] a, logic [63:0] b, logic te);
    logic [66:0] e = model(a, b, te);
    if (e[64]) return "R3";
    if (is_nan(a)) return "R5";
    if (is_nan(b)) return "R6";
    if ((is_inf(a) || is_inf(b)) && (is_zero(a) || is_zero(b))) return "R2";
    if (is_inf(a) || is_inf(b)) return "R4";
    if (is_zero(a) || is_zero(b)) return "R7";
    return "R8";
  endfunction

  task automatic apply(logic [63:0] a, logic [63:0] b, logic te, string tag);
    logic [66:0] exp_v;
    logic [66:0] got;
    @(negedge clk);
    op_a = a; op_b = b; inv_trap_en = te;
    #1;
    exp_v = model(a, b, te);
    got = {byp_valid, inv_flag_set, inv_trap_req, byp_result};
    checks++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL %s a=%h b=%h te=%0b actual=%h expected=%h", tag, a, b, te, got, exp_v);
    end
    // R9: flag and trap exclusive, trap only with enable
    checks++;
    if ((inv_flag_set && inv_trap_req) || (inv_trap_req && !te)) begin
      errors++;
      $display("FAIL R9 actual flag=%0b trap=%0b te=%0b expected exclusive", inv_flag_set, inv_trap_req, te);
    end
  endtask

  function automatic logic [63:0] gen(int cls);
    logic sg = 1'($urandom);
    logic [51:0] m = {$urandom, $urandom};
    logic [10:0] e = 11'($urandom_range(1, 2046));
    case (cls)
      0: return {sg, 63'd0};
      1: return {sg, 11'd0, (m == 0 ? 52'd1 : m)};
      2: return {sg, e, m};
      3: return {sg, 11'h7FF, 52'd0};
      4: return {sg, 11'h7FF, 1'b1, m[50:0]};
      default: return {sg, 11'h7FF, 1'b0, m[50:1], 1'b1};
    endcase
  endfunction

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] x, y;
    void'($urandom(32'd1234));
    op_a = 0; op_b = 0; inv_trap_en = 0;
    // R8 normal x normal: idle
    apply(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 0, "R8");
    // R8 subnormal x normal
    apply(64'h0000_0000_0000_0001, 64'hC000_0000_0000_0000, 0, "R8");
    // R2 inf x zero, both orders
    apply(64'hFFF0_0000_0000_0000, 64'h0000_0000_0000_0000, 0, "R2");
    apply(64'h8000_0000_0000_0000, 64'h7FF0_0000_0000_0000, 0, "R2");
    // R3 trap enabled cases
    apply(64'h7FF0_0000_0000_0000, 64'h8000_0000_0000_0000, 1, "R3");
    apply(64'h7FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000, 1, "R3");
    // R4 / R1 inf x finite and inf x inf
    apply(64'hFFF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 0, "R4");
    apply(64'h0000_0000_0000_0005, 64'hFFF0_0000_0000_0000, 0, "R4");
    apply(64'hFFF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 0, "R1");
    // R5 priority
    apply(64'h7FF0_0000_0000_0002, 64'hFFF0_0000_0000_0003, 0, "R5");
    apply(64'hFFF8_0000_0000_0002, 64'h7FF0_0000_0000_0003, 0, "R5");
    apply(64'hFFF8_0000_0000_0002, 64'h7FF8_0000_0000_0003, 0, "R5");
    apply(64'h7FFC_0000_0000_0000, 64'h0000_0000_0000_0000, 1, "R5");
    // R6 only B NaN
    apply(64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0009, 0, "R6");
    apply(64'h0000_0000_0000_0000, 64'hFFF8_0000_0000_0009, 1, "R6");
    // R7 zero x finite
    apply(64'h8000_0000_0000_0000, 64'h8010_0000_0000_0000, 0, "R7");
    apply(64'h4000_0000_0000_0000, 64'h0000_0000_0000_0000, 1, "R7");
    for (int i = 0; i < 3000; i++) begin
      logic te;
      x = gen($urandom_range(0, 5));
      y = gen($urandom_range(0, 5));
      te = 1'($urandom);
      apply(x, y, te, tag_of(x, y, te));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1'b1;
    $finish;
  end

endmodule